// File: doc/BRIEF.md
# Maximal-Length Pseudo-Noise Sequence Generator

This block steps a linear feedback shift register through a maximal-length sequence and emits one pseudo-noise bit per enabled clock. A single tap mask, given as a parameter, describes the primitive polynomial. A second parameter builds the register either with the feedback XOR gathered into the top stage (external form) or with the XORs spread across the tapped stages (internal form). Both forms shift right and emit bit 0, and for the same mask they give the same output stream.

A run-time select turns on complement (XNOR-style) feedback. In that mode the forbidden lockup word is all ones instead of all zeros. The block guards against lockup in two places. A seed that is the forbidden word for the current mode is replaced by a fixed legal value. An enabled step taken from the forbidden word, which can happen after the mode select changes, restores that same legal value. A one-cycle flag marks each return of the register to the seed it was last given, so the block can also act as a period marker or a clock divider.

Top module: `pn_seq_gen`

## Requirements
- R1: In the cycle after a synchronous reset, the state equals parameter SAFE_SEED (default 1), seed_hit_o is low, and the reference seed is SAFE_SEED.
- R2: With step_en_i low and seed_load_i low, the state and seed_hit_o are held unchanged apart from seed_hit_o going low.
- R3: seed_load_i loads seed_i on the next edge whether or not step_en_i is high, and a load wins over a step in the same cycle.
- R4: A loaded seed equal to the forbidden word is replaced by SAFE_SEED when xnor_mode_i is 0 (forbidden word all zeros), or by ~SAFE_SEED when xnor_mode_i is 1 (forbidden word all ones).
- R5: External form: the state shifts right, the new bit W-1 is the XOR of state bits W-k over every tap k, where bit k-1 of TAPS set means tap k, and pn_bit_o is state bit 0. For 3 stages with TAPS=3'b101, seed 3'b111 emits 1110100 and seed 3'b001 emits 1001110, repeating, first bit first.
- R6: Internal form: the state shifts right and, if the bit shifted out was 1, is XORed with TAPS. With 16 stages and TAPS=16'hB400, state 16'hACE1 steps to 16'hE270.
- R7: For the same TAPS the internal form emits the same stream as the external form. With 3 stages and TAPS=3'b101, seed 3'b001 gives 1110100 in the internal form.
- R8: With a primitive TAPS the state repeats after exactly 2^W-1 steps. For the 16-stage default mask, both forms first return to the seed on step 65535.
- R9: With xnor_mode_i high, each step maps state S to the complement of the XOR-mode successor of ~S, so the whole trajectory and stream are the complement of the XOR-mode ones.
- R10: seed_hit_o is high for exactly the one cycle after an enabled step whose result equals the reference seed (the last loaded value after substitution). It is low after load cycles and after hold cycles.
- R11: An enabled step taken while the state equals the forbidden word of the current mode sets the state to SAFE_SEED in XOR mode, or to ~SAFE_SEED in XNOR mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| step_en_i | input | 1 | Advance the register one step |
| seed_load_i | input | 1 | Load seed_i (priority over stepping) |
| seed_i | input | WIDTH | Seed value to load |
| xnor_mode_i | input | 1 | 1 selects complement feedback |
| pn_bit_o | output | 1 | Serial pseudo-noise bit (state bit 0) |
| pn_state_o | output | WIDTH | Full register state |
| seed_hit_o | output | 1 | One-cycle mark of a return to the reference seed |

## Verification
The properties take it that TAPS is a primitive mask with tap W set and that SAFE_SEED is neither all zeros nor all ones. Without that, the no-lockup and single-cycle-flag properties would not hold. They also assume the reset is asserted from time zero and that inputs are known at every edge once reset is released. The stimulus only uses primitive masks (3'b101, 16'hB400), keeps the default seed, and changes xnor_mode_i only in the recovery scenario. In that scenario the state is forbidden for the new mode on purpose.

// File: rtl/pn_pkg.sv
package pn_pkg;

    // Register organisation: feedback gathered into the top stage, or
    // spread across the tapped stages.
    typedef enum logic {
        PN_EXTERNAL = 1'b0,
        PN_INTERNAL = 1'b1
    } pn_form_e;

    // Feedback polarity selected at run time.
    typedef enum logic {
        PN_POL_XOR  = 1'b0,
        PN_POL_XNOR = 1'b1
    } pn_pol_e;

    // Decoded per-cycle request.
    typedef struct packed {
        logic    load;
        logic    step;
        pn_pol_e pol;
    } pn_req_t;

    function automatic pn_req_t pn_decode(input logic load, input logic en, input logic xnor_sel);
        pn_req_t r;
        r.load = load;
        r.step = en & ~load;
        r.pol  = xnor_sel ? PN_POL_XNOR : PN_POL_XOR;
        return r;
    endfunction

endpackage

// File: rtl/pn_next_state.sv
module pn_next_state
    import pn_pkg::*;
#(
    parameter int                WIDTH = 16,
    parameter logic [WIDTH-1:0]  TAPS  = 16'hB400,
    parameter pn_form_e          FORM  = PN_INTERNAL
) (
    input  logic [WIDTH-1:0] cur_i,
    input  pn_pol_e          pol_i,
    output logic [WIDTH-1:0] nxt_o
);

    // Tap k (bit k-1 of TAPS) reads state bit WIDTH-k in the external form.
    function automatic logic [WIDTH-1:0] mirror(input logic [WIDTH-1:0] t);
        logic [WIDTH-1:0] m;
        for (int i = 0; i < WIDTH; i++) begin
            m[i] = t[WIDTH-1-i];
        end
        return m;
    endfunction

    localparam logic [WIDTH-1:0] EXT_SEL = mirror(TAPS);

    logic [WIDTH-1:0] pol_mask;
    logic [WIDTH-1:0] core_in;
    logic [WIDTH-1:0] core_out;

    // XNOR mode runs the XOR core on the complemented word.
    assign pol_mask = {WIDTH{pol_i == PN_POL_XNOR}};
    assign core_in  = cur_i ^ pol_mask;

    generate
        if (FORM == PN_INTERNAL) begin : g_internal
            logic [WIDTH-1:0] toggle;
            assign toggle   = {WIDTH{core_in[0]}} & TAPS;
            assign core_out = {1'b0, core_in[WIDTH-1:1]} ^ toggle;
        end else begin : g_external
            logic fb;
            assign fb       = ^(core_in & EXT_SEL);
            assign core_out = {fb, core_in[WIDTH-1:1]};
        end
    endgenerate

    assign nxt_o = core_out ^ pol_mask;

endmodule

// File: rtl/pn_seed_guard.sv
module pn_seed_guard
    import pn_pkg::*;
#(
    parameter int               WIDTH     = 16,
    parameter logic [WIDTH-1:0] SAFE_SEED = 1
) (
    input  logic [WIDTH-1:0] cand_i,
    input  pn_pol_e          pol_i,
    output logic             bad_o,
    output logic [WIDTH-1:0] safe_o,
    output logic [WIDTH-1:0] value_o
);

    logic [WIDTH-1:0] forbidden;

    always_comb begin
        forbidden = (pol_i == PN_POL_XNOR) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
        safe_o    = (pol_i == PN_POL_XNOR) ? ~SAFE_SEED : SAFE_SEED;
        bad_o     = (cand_i == forbidden);
        value_o   = bad_o ? safe_o : cand_i;
    end

endmodule

// File: rtl/pn_wrap_mon.sv
module pn_wrap_mon #(
    parameter int               WIDTH     = 16,
    parameter logic [WIDTH-1:0] SAFE_SEED = 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] step_val_i,
    output logic             hit_o
);

    logic [WIDTH-1:0] ref_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ref_q <= SAFE_SEED;
            hit_o <= 1'b0;
        end else begin
            if (load_i) begin
                ref_q <= load_val_i;
            end
            hit_o <= step_i && !load_i && (step_val_i == ref_q);
        end
    end

    // R10: a mark lasts a single cycle
    a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_o |=> !hit_o);

    // R10: a mark only follows a step cycle
    a_r10_after_step: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_o |-> $past(step_i && !load_i));

endmodule

// File: rtl/pn_seq_gen.sv
module pn_seq_gen
    import pn_pkg::*;
#(
    parameter int               WIDTH     = 16,
    parameter logic [WIDTH-1:0] TAPS      = 16'hB400,
    parameter pn_form_e         FORM      = PN_INTERNAL,
    parameter logic [WIDTH-1:0] SAFE_SEED = 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             step_en_i,
    input  logic             seed_load_i,
    input  logic [WIDTH-1:0] seed_i,
    input  logic             xnor_mode_i,
    output logic             pn_bit_o,
    output logic [WIDTH-1:0] pn_state_o,
    output logic             seed_hit_o
);

    localparam logic [WIDTH-1:0] ZEROS = '0;
    localparam logic [WIDTH-1:0] ONES  = '1;

    pn_req_t          req;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] nxt_raw;
    logic [WIDTH-1:0] step_val;
    logic [WIDTH-1:0] seed_fixed;
    logic [WIDTH-1:0] seed_safe;
    logic [WIDTH-1:0] cur_safe;
    logic [WIDTH-1:0] cur_pass;
    logic             seed_bad;
    logic             cur_bad;

    assign req = pn_decode(seed_load_i, step_en_i, xnor_mode_i);

    pn_next_state #(.WIDTH(WIDTH), .TAPS(TAPS), .FORM(FORM)) u_next (
        .cur_i (state_q),
        .pol_i (req.pol),
        .nxt_o (nxt_raw)
    );

    pn_seed_guard #(.WIDTH(WIDTH), .SAFE_SEED(SAFE_SEED)) u_seed_guard (
        .cand_i  (seed_i),
        .pol_i   (req.pol),
        .bad_o   (seed_bad),
        .safe_o  (seed_safe),
        .value_o (seed_fixed)
    );

    pn_seed_guard #(.WIDTH(WIDTH), .SAFE_SEED(SAFE_SEED)) u_state_guard (
        .cand_i  (state_q),
        .pol_i   (req.pol),
        .bad_o   (cur_bad),
        .safe_o  (cur_safe),
        .value_o (cur_pass)
    );

    // A step out of the forbidden word restores the legal seed instead.
    assign step_val = cur_bad ? cur_pass : nxt_raw;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SAFE_SEED;
        end else if (req.load) begin
            state_q <= seed_fixed;
        end else if (req.step) begin
            state_q <= step_val;
        end
    end

    pn_wrap_mon #(.WIDTH(WIDTH), .SAFE_SEED(SAFE_SEED)) u_wrap (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (req.load),
        .load_val_i (seed_fixed),
        .step_i     (req.step),
        .step_val_i (step_val),
        .hit_o      (seed_hit_o)
    );

    assign pn_state_o = state_q;
    assign pn_bit_o   = state_q[0];

    // R2: idle cycles keep the state
    a_r2_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!step_en_i && !seed_load_i) |=> $stable(pn_state_o));

    // R3: a legal seed lands unchanged, even with enable high
    a_r3_load: assert property (@(posedge clk_i) disable iff (rst_i)
        (seed_load_i && (seed_i != {WIDTH{xnor_mode_i}})) |=> pn_state_o == $past(seed_i));

    // R4: a forbidden seed becomes the mode's legal seed
    a_r4_subst: assert property (@(posedge clk_i) disable iff (rst_i)
        (seed_load_i && (seed_i == {WIDTH{xnor_mode_i}}))
        |=> pn_state_o == ($past(xnor_mode_i) ? ~SAFE_SEED : SAFE_SEED));

    // R11: no step or load leaves the register in the forbidden word of its mode
    a_r11_no_lockup: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_en_i || seed_load_i) |=> pn_state_o != ($past(xnor_mode_i) ? ONES : ZEROS));

    // R5/R6: the low WIDTH-1 bits are the previous upper bits shifted down,
    // except for the tap flips of the internal form
    generate
        if (FORM == PN_EXTERNAL) begin : g_chk_ext
            a_r5_shift: assert property (@(posedge clk_i) disable iff (rst_i)
                (step_en_i && !seed_load_i && (state_q != {WIDTH{xnor_mode_i}}))
                |=> pn_state_o[WIDTH-2:0] == $past(pn_state_o[WIDTH-1:1]));
        end else begin : g_chk_int
            a_r6_plain_shift: assert property (@(posedge clk_i) disable iff (rst_i)
                (step_en_i && !seed_load_i && !xnor_mode_i && !state_q[0] && (state_q != ZEROS))
                |=> pn_state_o == {1'b0, $past(pn_state_o[WIDTH-1:1])});
        end
    endgenerate

endmodule

// File: tb/pn_seq_gen_test.sv
module pn_seq_gen_test;
    import pn_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // 16-stage pair
    logic        e16 = 0, l16 = 0, x16 = 0;
    logic [15:0] s16 = '0;
    logic        b_g16, b_f16, h_g16, h_f16;
    logic [15:0] q_g16, q_f16;

    // 3-stage pair
    logic        e3 = 0, l3 = 0, x3 = 0;
    logic [2:0]  s3 = '0;
    logic        b_f3, b_g3, h_f3, h_g3;
    logic [2:0]  q_f3, q_g3;

    pn_seq_gen uut (
        .clk_i(clk), .rst_i(rst), .step_en_i(e16), .seed_load_i(l16),
        .seed_i(s16), .xnor_mode_i(x16), .pn_bit_o(b_g16),
        .pn_state_o(q_g16), .seed_hit_o(h_g16));

    pn_seq_gen #(.WIDTH(16), .TAPS(16'hB400), .FORM(PN_EXTERNAL), .SAFE_SEED(16'h0001)) uut_fib16 (
        .clk_i(clk), .rst_i(rst), .step_en_i(e16), .seed_load_i(l16),
        .seed_i(s16), .xnor_mode_i(x16), .pn_bit_o(b_f16),
        .pn_state_o(q_f16), .seed_hit_o(h_f16));

    pn_seq_gen #(.WIDTH(3), .TAPS(3'b101), .FORM(PN_EXTERNAL), .SAFE_SEED(3'b001)) uut_fib3 (
        .clk_i(clk), .rst_i(rst), .step_en_i(e3), .seed_load_i(l3),
        .seed_i(s3), .xnor_mode_i(x3), .pn_bit_o(b_f3),
        .pn_state_o(q_f3), .seed_hit_o(h_f3));

    pn_seq_gen #(.WIDTH(3), .TAPS(3'b101), .FORM(PN_INTERNAL), .SAFE_SEED(3'b001)) uut_gal3 (
        .clk_i(clk), .rst_i(rst), .step_en_i(e3), .seed_load_i(l3),
        .seed_i(s3), .xnor_mode_i(x3), .pn_bit_o(b_g3),
        .pn_state_o(q_g3), .seed_hit_o(h_g3));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Independent models from R5 and R6 for the 16-stage mask
    function automatic logic [15:0] model_ext(input logic [15:0] s);
        logic fb;
        fb = s[0] ^ s[2] ^ s[3] ^ s[5];
        return {fb, s[15:1]};
    endfunction

    function automatic logic [15:0] model_int(input logic [15:0] s);
        return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    task automatic t_reset;
        @(negedge clk);
        chk(q_g16 == 16'h0001, "R1 internal reset state", q_g16, 16'h0001);
        chk(q_f16 == 16'h0001, "R1 external reset state", q_f16, 16'h0001);
        chk(q_f3 == 3'b001 && q_g3 == 3'b001, "R1 3-stage reset state", {q_f3, q_g3}, 6'o11);
        chk(!h_g16 && !h_f16 && !h_f3 && !h_g3, "R1 flag low", {h_g16, h_f16, h_f3, h_g3}, 0);
    endtask

    task automatic t_priority_hold;
        @(negedge clk);
        l16 = 1; e16 = 1; s16 = 16'hACE1;
        @(negedge clk);
        l16 = 0; e16 = 0;
        chk(q_g16 == 16'hACE1, "R3 load wins over step (internal)", q_g16, 16'hACE1);
        chk(q_f16 == 16'hACE1, "R3 load wins over step (external)", q_f16, 16'hACE1);
        repeat (5) @(negedge clk);
        chk(q_g16 == 16'hACE1 && q_f16 == 16'hACE1, "R2 hold with enable low", q_g16, 16'hACE1);
        chk(!h_g16 && !h_f16, "R2 no flag while holding", h_g16, 0);
        e16 = 1;
        @(negedge clk);
        e16 = 0;
        chk(q_g16 == 16'hE270, "R6 internal single step", q_g16, 16'hE270);
        chk(q_f16 == 16'h5670, "R5 external single step", q_f16, 16'h5670);
    endtask

    task automatic t_period16;
        logic [15:0] mg, mf;
        int bad_g, bad_f, early;
        bad_g = 0; bad_f = 0; early = 0;
        @(negedge clk);
        l16 = 1; s16 = 16'hACE1; x16 = 0;
        @(negedge clk);
        l16 = 0; e16 = 1;
        mg = 16'hACE1; mf = 16'hACE1;
        for (int i = 1; i <= 65535; i++) begin
            @(negedge clk);
            mg = model_int(mg);
            mf = model_ext(mf);
            if (q_g16 != mg) bad_g++;
            if (q_f16 != mf) bad_f++;
            if (i < 65535 && (h_g16 || h_f16)) early++;
        end
        e16 = 0;
        chk(bad_g == 0, "R6 internal trajectory mismatches", bad_g, 0);
        chk(bad_f == 0, "R5 external trajectory mismatches", bad_f, 0);
        chk(early == 0, "R8 no early return to seed", early, 0);
        chk(h_g16 && h_f16, "R8 return to seed at step 65535", {h_g16, h_f16}, 2'b11);
        chk(q_g16 == 16'hACE1 && q_f16 == 16'hACE1, "R8 state back at seed", q_g16, 16'hACE1);
        @(negedge clk);
        chk(!h_g16 && !h_f16, "R10 flag lasts one cycle", {h_g16, h_f16}, 0);
    endtask

    // Load a seed into both 3-stage units and collect one period of output.
    task automatic t_stream3(input logic [2:0] seed, input logic xm,
                             input logic [6:0] exp_f, input logic [6:0] exp_g, input string req);
        logic [6:0] got_f, got_g;
        int early;
        got_f = '0; got_g = '0; early = 0;
        @(negedge clk);
        l3 = 1; s3 = seed; x3 = xm; e3 = 0;
        @(negedge clk);
        l3 = 0; e3 = 1;
        chk(!h_f3 && !h_g3, {req, " flag low after load (R10)"}, {h_f3, h_g3}, 0);
        for (int i = 0; i < 7; i++) begin
            if (i > 0 && (h_f3 || h_g3)) early++;
            got_f = {got_f[5:0], b_f3};
            got_g = {got_g[5:0], b_g3};
            @(negedge clk);
        end
        e3 = 0;
        chk(got_f == exp_f, {req, " external stream"}, got_f, exp_f);
        chk(got_g == exp_g, {req, " internal stream"}, got_g, exp_g);
        chk(early == 0 && h_f3 && h_g3, {req, " period 7 mark (R10)"}, {early[3:0], h_f3, h_g3}, 6'b000011);
    endtask

    task automatic t_subst;
        @(negedge clk);
        l3 = 1; s3 = 3'b000; x3 = 0;
        @(negedge clk);
        l3 = 0;
        chk(q_f3 == 3'b001 && q_g3 == 3'b001, "R4 zero seed replaced", {q_f3, q_g3}, 6'o11);
        l3 = 1; s3 = 3'b111; x3 = 1;
        @(negedge clk);
        l3 = 0; x3 = 0;
        chk(q_f3 == 3'b110 && q_g3 == 3'b110, "R4 ones seed replaced in XNOR mode", {q_f3, q_g3}, 6'o66);
    endtask

    task automatic t_recover;
        @(negedge clk);
        l3 = 1; s3 = 3'b111; x3 = 0;
        @(negedge clk);
        l3 = 0; x3 = 1; e3 = 1;
        @(negedge clk);
        e3 = 0; x3 = 0;
        chk(q_f3 == 3'b110 && q_g3 == 3'b110, "R11 step out of lockup word", {q_f3, q_g3}, 6'o66);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_priority_hold();
        t_period16();
        t_stream3(3'b111, 1'b0, 7'b1110100, 7'b1010011, "R5 seed 111");
        t_stream3(3'b001, 1'b0, 7'b1001110, 7'b1110100, "R7 seed 001");
        t_stream3(3'b110, 1'b1, 7'b0110001, 7'b0001011, "R9 XNOR seed 110");
        t_stream3(3'b000, 1'b0, 7'b1001110, 7'b1110100, "R4 substituted seed");
        t_subst();
        t_recover();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule